// File: doc/BRIEF.md
# 8B/10B Receive Symbol Decoder Output Stage

This block sits behind a deserializer that has already found the symbol boundaries. Each time the byte strobe is high, it takes one aligned 10-bit line symbol. It then loads a new set of outputs, which stay constant until the next strobe. In encoded mode the symbol is decoded against the running disparity and produces four outputs:

- the recovered byte;
- a flag that marks control (K) characters;
- a code-violation flag;
- a sync flag that separates fresh characters from the idle pad character.

In bypass mode the decoder is skipped. The ten raw symbol bits are placed on the same ten output pins, and the running disparity is left alone.

The running disparity is kept inside the block, and every encoded symbol is checked against it. An illegal symbol raises the violation flag and clears the byte and both character flags, so the stage downstream sees a plain error marker and no partly decoded value.

Top module: `sym10_rx_stage`

## Requirements
- R1: After reset, all four outputs are LOW and the running disparity is negative. The first K28.5 symbol in its negative-disparity form is therefore accepted without a violation.
- R2: The outputs change only on a rising clock edge at which `symStrobe` is HIGH. On any other edge they hold their value, whatever `symIn` and `modeBypass` do.
- R3: Bit order and data decoding in encoded mode:
  - `symIn[0]` to `symIn[9]` carry the line bits a, b, c, d, e, i, f, g, h, j.
  - The 6-bit group abcdei decodes to EDCBA and the 4-bit group fghj decodes to HGF.
  - A valid data character gives `dataOut` = {HGF, EDCBA}, `ctrlFlag` = 0, `violation` = 0 and `syncOut` = 1.
- R4: The twelve valid control characters each give `ctrlFlag` = 1, their byte on `dataOut`, `violation` = 0 and `syncOut` = 1. The exception is K28.5 (R5).
  - K28.0 to K28.7 have the bytes 1C, 3C, 5C, 7C, 9C, BC, DC and FC.
  - K23.7, K27.7, K29.7 and K30.7 have the bytes F7, FB, FD and FE.
- R5: K28.5 in either disparity is the pad character. It gives `syncOut` = 0, `ctrlFlag` = 1, `dataOut` = BC and `violation` = 0.
- R6: In encoded mode, the following symbols give `violation` = 1 with `dataOut` = 0, `ctrlFlag` = 0 and `syncOut` = 0:
  - a 6-bit or 4-bit group that is not a code group;
  - a wrong choice between the primary and alternate code for HGF = 7.
- R7: In encoded mode, a symbol that is a legal code only under the opposite running disparity gives the same zeroed outputs as R6, with `violation` = 1.
- R8: After each encoded-mode strobe, the running disparity is updated from the number of ones in the symbol:
  - more than five ones makes it positive;
  - fewer than five ones makes it negative;
  - exactly five ones leaves it unchanged.
  - Strobes in bypass mode do not change it.
- R9: In bypass mode a strobe loads:
  - `ctrlFlag` = `symIn[0]` (bit a);
  - `dataOut` = `symIn[8:1]` (bits b, c, d, e, i, f, g, h on data bits 0 to 7);
  - `violation` = `symIn[9]` (bit j);
  - `syncOut` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| symStrobe | input | 1 | Load strobe: one aligned symbol is present |
| modeBypass | input | 1 | 1 = raw symbol passthrough, 0 = decode |
| symIn | input | 10 | Aligned line symbol, bit a in bit 0 |
| dataOut | output | 8 | Decoded byte, or raw bits b to h in bypass mode |
| ctrlFlag | output | 1 | Control-character flag, or raw bit a in bypass mode |
| violation | output | 1 | Code-rule violation flag, or raw bit j in bypass mode |
| syncOut | output | 1 | New character ready (LOW for the pad character, errors and bypass mode) |

## Verification
The one hidden state is the running-disparity bit. If it is wrong, nothing shows while the symbols are disparity-neutral. The error appears at the ports on the first unbalanced symbol: a spurious `violation` on a clean stream, or a missed one on a flipped stream, one strobe after the symbol arrives. The stimulus therefore interleaves neutral and unbalanced codes, wrong-disparity codes and bypass strobes. That way a lost, stuck or bypass-corrupted disparity bit is exposed within a few symbols. A wrong lookup entry or swapped bit order shows up in the very next strobe as a byte that differs from the one encoded.

// File: rtl/sym10_pkg.sv
package sym10_pkg;
  localparam int SYM_W  = 10;
  localparam int SIX_W  = 6;
  localparam int FOUR_W = 4;
  localparam int X_W    = 5;
  localparam int Y_W    = 3;
  localparam int BYTE_W = X_W + Y_W;
  localparam int E_POS  = 4;
  localparam int I_POS  = 5;
  localparam int HALF_ONES = SYM_W / 2;
  localparam logic [X_W-1:0] K28_X = 5'd28;
  localparam logic [Y_W-1:0] PAD_Y = 3'd5;
  localparam logic [BYTE_W-1:0] PAD_CODE = {PAD_Y, K28_X};

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic bypass;
  } ctlStrobe_t;

  // decoder result for the current symbol
  typedef struct packed {
    logic [BYTE_W-1:0] byteVal;
    logic              isCtrl;
    logic              bad;
    logic              isPad;
  } decRes_t;
endpackage

// File: rtl/sym10_decode.sv
module sym10_decode
  import sym10_pkg::*;
(
  input  logic [SYM_W-1:0] symIn,
  input  logic             rdPos,
  output decRes_t          res,
  output logic             rdPosNext
);
  logic [SIX_W-1:0]  six, sixN;
  logic [FOUR_W-1:0] four, fourN;

  // line order a..i into six (a at MSB), f..j into four (f at MSB)
  for (genvar k = 0; k < SIX_W; k++) begin : g_six
    assign six[SIX_W-1-k] = symIn[k];
  end
  for (genvar k = 0; k < FOUR_W; k++) begin : g_four
    assign four[FOUR_W-1-k] = symIn[SIX_W+k];
  end

  int sixOnes, fourOnes, allOnes;
  logic [X_W-1:0] xVal;
  logic [Y_W-1:0] yRaw, yVal;
  logic sixKnown, fourKnown, isK28, isA7, isP7;
  logic rdMid, sixDispOk, fourDispOk, altNeed, kx7, codeOk, bad, isCtrl;

  always_comb begin
    sixOnes  = $countones(six);
    fourOnes = $countones(four);
    allOnes  = $countones(symIn);
    // fold positive-disparity forms onto the negative-disparity form
    sixN  = ((sixOnes == 2) || (six == 6'b000111)) ? ~six : six;
    fourN = ((fourOnes == 1) || (four == 4'b0011)) ? ~four : four;
  end

  always_comb begin
    xVal = '0; sixKnown = 1'b1; isK28 = 1'b0;
    case (sixN)
      6'b100111: xVal = 5'd0;   6'b011101: xVal = 5'd1;
      6'b101101: xVal = 5'd2;   6'b110001: xVal = 5'd3;
      6'b110101: xVal = 5'd4;   6'b101001: xVal = 5'd5;
      6'b011001: xVal = 5'd6;   6'b111000: xVal = 5'd7;
      6'b111001: xVal = 5'd8;   6'b100101: xVal = 5'd9;
      6'b010101: xVal = 5'd10;  6'b110100: xVal = 5'd11;
      6'b001101: xVal = 5'd12;  6'b101100: xVal = 5'd13;
      6'b011100: xVal = 5'd14;  6'b010111: xVal = 5'd15;
      6'b011011: xVal = 5'd16;  6'b100011: xVal = 5'd17;
      6'b010011: xVal = 5'd18;  6'b110010: xVal = 5'd19;
      6'b001011: xVal = 5'd20;  6'b101010: xVal = 5'd21;
      6'b011010: xVal = 5'd22;  6'b111010: xVal = 5'd23;
      6'b110011: xVal = 5'd24;  6'b100110: xVal = 5'd25;
      6'b010110: xVal = 5'd26;  6'b110110: xVal = 5'd27;
      6'b001110: xVal = 5'd28;  6'b101110: xVal = 5'd29;
      6'b011110: xVal = 5'd30;  6'b101011: xVal = 5'd31;
      6'b001111: begin xVal = K28_X; isK28 = 1'b1; end
      default:   sixKnown = 1'b0;
    endcase
  end

  always_comb begin
    yRaw = '0; fourKnown = 1'b1; isA7 = 1'b0; isP7 = 1'b0;
    case (fourN)
      4'b1011: yRaw = 3'd0;
      4'b1001: yRaw = 3'd1;
      4'b0101: yRaw = 3'd2;
      4'b1100: yRaw = 3'd3;
      4'b1101: yRaw = 3'd4;
      4'b1010: yRaw = 3'd5;
      4'b0110: yRaw = 3'd6;
      4'b1110: begin yRaw = 3'd7; isP7 = 1'b1; end
      4'b0111: begin yRaw = 3'd7; isA7 = 1'b1; end
      default: fourKnown = 1'b0;
    endcase
  end

  always_comb begin
    // disparity legality of the 6-bit group and the disparity after it
    if (sixOnes == 3)
      sixDispOk = (six == 6'b111000) ? !rdPos : (six == 6'b000111) ? rdPos : 1'b1;
    else if (sixOnes == 4) sixDispOk = !rdPos;
    else if (sixOnes == 2) sixDispOk = rdPos;
    else                   sixDispOk = 1'b0;
    rdMid = (sixOnes == 4) ? 1'b1 : (sixOnes == 2) ? 1'b0 : rdPos;

    if (fourOnes == 2)
      fourDispOk = (four == 4'b1100) ? !rdMid : (four == 4'b0011) ? rdMid : 1'b1;
    else if (fourOnes == 3) fourDispOk = !rdMid;
    else if (fourOnes == 1) fourDispOk = rdMid;
    else                    fourDispOk = 1'b0;

    altNeed = rdMid ? (!symIn[E_POS] && !symIn[I_POS]) : (symIn[E_POS] && symIn[I_POS]);
    kx7 = (xVal == 5'd23) || (xVal == 5'd27) || (xVal == 5'd29) || (xVal == 5'd30);

    yVal = yRaw;
    if (isK28) begin
      codeOk = !isP7;
      isCtrl = 1'b1;
      // after a low-weight K28 group the 1/6 and 2/5 codes swap meaning
      if (!rdMid) begin
        case (yRaw)
          3'd1: yVal = 3'd6;  3'd6: yVal = 3'd1;
          3'd2: yVal = 3'd5;  3'd5: yVal = 3'd2;
          default: yVal = yRaw;
        endcase
      end
    end else if (isA7) begin
      codeOk = altNeed || kx7;
      isCtrl = !altNeed && kx7;
    end else if (isP7) begin
      codeOk = !altNeed;
      isCtrl = 1'b0;
    end else begin
      codeOk = 1'b1;
      isCtrl = 1'b0;
    end

    bad = !(sixKnown && fourKnown && sixDispOk && fourDispOk && codeOk);
    res.bad     = bad;
    res.byteVal = bad ? '0 : {yVal, xVal};
    res.isCtrl  = !bad && isCtrl;
    res.isPad   = !bad && isK28 && (yVal == PAD_Y);

    rdPosNext = (allOnes > HALF_ONES) ? 1'b1 : (allOnes < HALF_ONES) ? 1'b0 : rdPos;
  end
endmodule

// File: rtl/sym10_ctrl.sv
module sym10_ctrl
  import sym10_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       symStrobe,
  input  logic       modeBypass,
  input  logic       rdPosNext,
  output logic       rdPos,
  output ctlStrobe_t ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rdPos <= 1'b0;
    else if (symStrobe && !modeBypass) rdPos <= rdPosNext;
  end

  always_comb begin
    ctl.load   = symStrobe;
    ctl.bypass = modeBypass;
  end

  // R8: a bypass strobe leaves the disparity alone
  p_rd_bypass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(symStrobe && modeBypass) |-> rdPos == $past(rdPos));
endmodule

// File: rtl/sym10_outpath.sv
module sym10_outpath
  import sym10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        ctl,
  input  logic [SYM_W-1:0]  symIn,
  input  decRes_t           res,
  output logic [BYTE_W-1:0] dataOut,
  output logic              ctrlFlag,
  output logic              violation,
  output logic              syncOut
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataOut <= '0; ctrlFlag <= 1'b0; violation <= 1'b0; syncOut <= 1'b0;
    end else if (ctl.load) begin
      if (ctl.bypass) begin
        ctrlFlag  <= symIn[0];
        dataOut   <= symIn[BYTE_W:1];
        violation <= symIn[SYM_W-1];
        syncOut   <= 1'b0;
      end else begin
        dataOut   <= res.byteVal;
        ctrlFlag  <= res.isCtrl;
        violation <= res.bad;
        syncOut   <= !res.bad && !res.isPad;
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl.load) |-> $stable({dataOut, ctrlFlag, violation, syncOut}));

  p_zero_on_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl.load && !ctl.bypass) && violation) |-> (dataOut == '0 && !ctrlFlag && !syncOut));

  p_pad_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl.load && !ctl.bypass) && !syncOut && !violation) |-> (ctrlFlag && dataOut == PAD_CODE));

  p_bypass_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl.load && ctl.bypass) |-> (dataOut == $past(symIn[BYTE_W:1]) && !syncOut));
endmodule

// File: rtl/sym10_rx_stage.sv
module sym10_rx_stage
  import sym10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              symStrobe,
  input  logic              modeBypass,
  input  logic [SYM_W-1:0]  symIn,
  output logic [BYTE_W-1:0] dataOut,
  output logic              ctrlFlag,
  output logic              violation,
  output logic              syncOut
);
  ctlStrobe_t ctl;
  decRes_t    res;
  logic       rdPos, rdPosNext;

  sym10_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .symStrobe(symStrobe), .modeBypass(modeBypass),
    .rdPosNext(rdPosNext), .rdPos(rdPos), .ctl(ctl)
  );

  sym10_decode u_decode (
    .symIn(symIn), .rdPos(rdPos), .res(res), .rdPosNext(rdPosNext)
  );

  sym10_outpath u_outpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .symIn(symIn), .res(res),
    .dataOut(dataOut), .ctrlFlag(ctrlFlag), .violation(violation), .syncOut(syncOut)
  );
endmodule

// File: tb/sym10_rx_stage_bench.sv
module sym10_rx_stage_bench;
  logic clk = 1'b0, rst_n = 1'b0, symStrobe = 1'b0, modeBypass = 1'b0;
  logic [9:0] symIn = '0;
  logic [7:0] dataOut;
  logic ctrlFlag, violation, syncOut;

  int testsRun = 0, testsFailed = 0;
  bit finished = 1'b0;
  logic mRd = 1'b0;
  logic [7:0] eData = '0;
  logic eCtrl = 1'b0, eViol = 1'b0, eSync = 1'b0;

  always #10 clk = ~clk;

  sym10_rx_stage u_sym10_rx_stage (
    .clk(clk), .rst_n(rst_n), .symStrobe(symStrobe), .modeBypass(modeBypass),
    .symIn(symIn), .dataOut(dataOut), .ctrlFlag(ctrlFlag), .violation(violation),
    .syncOut(syncOut)
  );

  // 5-bit to abcdei, negative-disparity column
  function automatic logic [5:0] enc6Neg(input logic [4:0] x);
    case (x)
      5'd0: return 6'b100111;   5'd1: return 6'b011101;   5'd2: return 6'b101101;
      5'd3: return 6'b110001;   5'd4: return 6'b110101;   5'd5: return 6'b101001;
      5'd6: return 6'b011001;   5'd7: return 6'b111000;   5'd8: return 6'b111001;
      5'd9: return 6'b100101;   5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;  5'd14: return 6'b011100;
      5'd15: return 6'b010111;  5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;  5'd20: return 6'b001011;
      5'd21: return 6'b101010;  5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;  5'd26: return 6'b010110;
      5'd27: return 6'b110110;  5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] enc4Neg(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011; 3'd1: return 4'b1001; 3'd2: return 4'b0101; 3'd3: return 4'b1100;
      3'd4: return 4'b1101; 3'd5: return 4'b1010; 3'd6: return 4'b0110; default: return 4'b1110;
    endcase
  endfunction

  function automatic logic [3:0] k28Neg4(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011; 3'd1: return 4'b0110; 3'd2: return 4'b1010; 3'd3: return 4'b1100;
      3'd4: return 4'b1101; 3'd5: return 4'b0101; 3'd6: return 4'b1001; default: return 4'b0111;
    endcase
  endfunction

  function automatic logic [9:0] packSym(input logic [5:0] s6, input logic [3:0] f4);
    logic [9:0] v;
    for (int k = 0; k < 6; k++) v[k] = s6[5-k];
    for (int k = 0; k < 4; k++) v[6+k] = f4[3-k];
    return v;
  endfunction

  function automatic logic [9:0] encode(input logic [7:0] b, input logic isK, input logic rd);
    logic [5:0] s6; logic [3:0] f4; logic rdm, k28, alt;
    k28 = isK && (b[4:0] == 5'd28);
    s6 = k28 ? 6'b001111 : enc6Neg(b[4:0]);
    if (rd && ($countones(s6) != 3 || s6 == 6'b111000)) s6 = ~s6;
    rdm = ($countones(s6) == 4) ? 1'b1 : ($countones(s6) == 2) ? 1'b0 : rd;
    alt = rdm ? (!s6[1] && !s6[0]) : (s6[1] && s6[0]);
    if (k28) begin
      f4 = k28Neg4(b[7:5]);
      if (rdm) f4 = ~f4;
    end else if (b[7:5] == 3'd7 && (isK || alt)) begin
      f4 = rdm ? 4'b1000 : 4'b0111;
    end else begin
      f4 = enc4Neg(b[7:5]);
      if (rdm && ($countones(f4) != 2 || f4 == 4'b1100)) f4 = ~f4;
    end
    return packSym(s6, f4);
  endfunction

  function automatic logic [7:0] kByte(input int idx);
    if (idx < 8) return {3'(idx), 5'd28};
    case (idx)
      8: return 8'hF7; 9: return 8'hFB; 10: return 8'hFD; default: return 8'hFE;
    endcase
  endfunction

  // brute-force decode: which legal character encodes to v under rd
  task automatic modelDecode(input logic [9:0] v, input logic rd,
                             output logic ok, output logic [7:0] b, output logic k);
    ok = 1'b0; b = '0; k = 1'b0;
    for (int n = 0; n < 268; n++) begin
      logic [7:0] cand; logic cK;
      cand = (n < 256) ? 8'(n) : kByte(n - 256);
      cK = (n >= 256);
      if (!ok && encode(cand, cK, rd) == v) begin ok = 1'b1; b = cand; k = cK; end
    end
  endtask

  task automatic checkOut(input string tag);
    testsRun++;
    if (dataOut !== eData || ctrlFlag !== eCtrl || violation !== eViol || syncOut !== eSync) begin
      testsFailed++;
      $display("FAIL %s: got data=%h ctrl=%b viol=%b sync=%b, expected data=%h ctrl=%b viol=%b sync=%b",
               tag, dataOut, ctrlFlag, violation, syncOut, eData, eCtrl, eViol, eSync);
    end
  endtask

  // called at a falling edge; checks one full cycle later
  task automatic apply(input logic s, input logic m, input logic [9:0] v, input string tag);
    logic ok, k; logic [7:0] b; int n;
    symStrobe = s; modeBypass = m; symIn = v;
    if (s) begin
      if (m) begin
        eData = v[8:1]; eCtrl = v[0]; eViol = v[9]; eSync = 1'b0;
      end else begin
        modelDecode(v, mRd, ok, b, k);
        if (ok) begin eData = b; eCtrl = k; eViol = 1'b0; eSync = !(k && b == 8'hBC); end
        else    begin eData = '0; eCtrl = 1'b0; eViol = 1'b1; eSync = 1'b0; end
        n = $countones(v);
        if (n > 5) mRd = 1'b1; else if (n < 5) mRd = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    checkOut(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: got running, expected finished");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    logic [7:0] rb, kb;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checkOut("R1 reset");
    apply(1'b1, 1'b0, encode(8'hBC, 1'b1, 1'b0), "R1 R5");
    apply(1'b1, 1'b0, encode(8'hBC, 1'b1, 1'b0), "R7 R8");
    apply(1'b1, 1'b0, encode(8'hBC, 1'b1, 1'b1), "R5");
    apply(1'b1, 1'b0, encode(8'hB5, 1'b0, mRd), "R3");
    apply(1'b1, 1'b0, encode(8'hE7, 1'b0, mRd), "R3");
    apply(1'b1, 1'b0, 10'h000, "R6");
    apply(1'b1, 1'b0, 10'h3FF, "R6");
    apply(1'b1, 1'b0, packSym(6'b111100, 4'b0101), "R6");
    apply(1'b1, 1'b0, encode(8'hF7, 1'b1, mRd), "R4");
    apply(1'b1, 1'b0, encode(8'hFE, 1'b1, mRd), "R4");
    apply(1'b1, 1'b1, 10'b1000000001, "R9");
    apply(1'b1, 1'b0, encode(8'h1C, 1'b1, mRd), "R8");
    apply(1'b0, 1'b0, encode(8'h00, 1'b0, mRd), "R2");
    for (int it = 0; it < 3000; it++) begin
      r  = $urandom % 100;
      rb = 8'($urandom);
      if (r < 45)      apply(1'b1, 1'b0, encode(rb, 1'b0, mRd), "R3");
      else if (r < 55) begin
        kb = kByte(int'($urandom % 12));
        apply(1'b1, 1'b0, encode(kb, 1'b1, mRd), (kb == 8'hBC) ? "R5" : "R4");
      end
      else if (r < 65) apply(1'b1, 1'b0, encode(rb, 1'b0, !mRd), "R7");
      else if (r < 75) apply(1'b1, 1'b0, 10'($urandom), "R6");
      else if (r < 87) apply(1'b1, 1'b1, 10'($urandom), "R9 R8");
      else             apply(1'b0, 1'($urandom), 10'($urandom), "R2");
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule